// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines toward a processor: a normal request (IRQ) and a fast request (FIQ). Each request line has its own enable mask. A request line is high while at least one source is active and enabled for that line. The two masks are independent, so a source may route to IRQ, to FIQ, to both or to neither.

Software reaches the controller through a word-addressed register port. Each mask has one write-one-to-set word and one write-one-to-clear word. Software reads a status word (level AND mask), a raw-level word and the mask itself. Source 0 can also be raised and lowered by software. That software flag is ORed with hardware source 0.

Controllers can be chained: the IRQ output of one instance may drive a source input of another. The block does no priority encoding and no vectoring.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both masks and the software flag are zero, and `irq_out` and `fiq_out` are low.
- R2: `src_in` is registered once per cycle into the raw level. Word 1 and word 9 both return this level. Bit 0 of the level is hardware source 0 ORed with the software flag.
- R3: A write to word 2 ORs the written bits into the IRQ mask. A write to word 3 clears the IRQ mask bits that are written as one. A read of word 2 returns the IRQ mask.
- R4: A write to word 10 ORs the written bits into the FIQ mask. A write to word 11 clears the FIQ mask bits that are written as one. A read of word 10 returns the FIQ mask.
- R5: Word 0 reads the raw level ANDed with the IRQ mask. Word 8 reads the raw level ANDed with the FIQ mask.
- R6: A write to word 4 with bit 0 set raises the software flag. A write to word 5 with bit 0 set lowers it. A write to either word with bit 0 clear leaves the flag unchanged. A read of word 4 returns level bit 0 in bit 0 and zero in all other bits.
- R7: `irq_out` (or `fiq_out`) goes high exactly one clock edge after the raw level ANDed with the IRQ (or FIQ) mask becomes nonzero, and goes low one edge after that value becomes zero.
- R8: A read of a write-only word (3, 5, 11) or of an unmapped word returns zero and asserts `bus_rderr` in the same cycle. Reads of mapped readable words do not assert it.
- R9: Writes to the status and raw words (0, 1, 8, 9) change neither mask nor the software flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Level-sensitive interrupt sources |
| bus_rd | input | 1 | Read strobe for the current word address |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| bus_rderr | output | 1 | Read of a write-only or unmapped word |
| irq_out | output | 1 | Registered normal interrupt request |
| fiq_out | output | 1 | Registered fast interrupt request |

## Verification
The bench checks that each mask keeps its untouched bits through set and clear writes, and that the two masks never affect each other. A design that crossed the mask decodes would raise the wrong request line. The bench also checks that clearing the software flag does not hide a hardware source 0 that is still active. A design that replaced bit 0 with the flag, instead of ORing it in, would drop that interrupt. The output latency is sampled on both sides of the single register stage, so a design that adds or removes a stage fails. Reads of write-only words, and writes to status words, are checked for the zero data, the error flag and masks that stay unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] WA_IRQ_STAT  = 6'd0;
    localparam logic [ADDR_W-1:0] WA_IRQ_RAW   = 6'd1;
    localparam logic [ADDR_W-1:0] WA_IRQ_SET   = 6'd2;
    localparam logic [ADDR_W-1:0] WA_IRQ_CLR   = 6'd3;
    localparam logic [ADDR_W-1:0] WA_SOFT_SET  = 6'd4;
    localparam logic [ADDR_W-1:0] WA_SOFT_CLR  = 6'd5;
    localparam logic [ADDR_W-1:0] WA_FIQ_STAT  = 6'd8;
    localparam logic [ADDR_W-1:0] WA_FIQ_RAW   = 6'd9;
    localparam logic [ADDR_W-1:0] WA_FIQ_SET   = 6'd10;
    localparam logic [ADDR_W-1:0] WA_FIQ_CLR   = 6'd11;

    localparam int N_CH = 2;

    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic fiq_set;
        logic fiq_clr;
        logic soft_set;
        logic soft_clr;
    } wr_strobe_t;

    function automatic logic is_status_word(input logic [ADDR_W-1:0] a);
        return (a == WA_IRQ_STAT) || (a == WA_IRQ_RAW) ||
               (a == WA_FIQ_STAT) || (a == WA_FIQ_RAW);
    endfunction
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (set_stb) mask_q <= mask_q | wbits;
        else if (clr_stb) mask_q <= mask_q & ~wbits;
    end

    // R3 and R4 share this register type
    a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> ((mask_q & $past(wbits)) == $past(wbits)));
    a_r3_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !set_stb) |=> ((mask_q & $past(wbits)) == '0));
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  logic             soft_set,
    input  logic             soft_clr,
    input  logic             wbit0,
    output logic [N_SRC-1:0] level
);
    logic [N_SRC-1:0] hw_q;
    logic             soft_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q   <= '0;
            soft_q <= 1'b0;
        end else begin
            hw_q <= src_in;
            if (soft_set && wbit0)      soft_q <= 1'b1;
            else if (soft_clr && wbit0) soft_q <= 1'b0;
        end
    end

    assign level = hw_q | {{(N_SRC-1){1'b0}}, soft_q};

    a_r6_soft_raise: assert property (@(posedge clk) disable iff (rst)
        (soft_set && wbit0) |=> level[0]);
    a_r6_soft_hold: assert property (@(posedge clk) disable iff (rst)
        !wbit0 |=> (soft_q == $past(soft_q)));
    a_r2_raw_sample: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level | {{(N_SRC-1){1'b0}}, 1'b1}) ==
                  ($past(src_in) | {{(N_SRC-1){1'b0}}, 1'b1})));
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  level,
    input  logic [N_SRC-1:0]  irq_en,
    input  logic [N_SRC-1:0]  fiq_en,
    output wr_strobe_t        stb,
    output logic [DATA_W-1:0] rdata,
    output logic              rderr
);
    logic bad_word;

    always_comb begin
        stb = '0;
        if (bus_wr) begin
            case (bus_addr)
                WA_IRQ_SET:  stb.irq_set  = 1'b1;
                WA_IRQ_CLR:  stb.irq_clr  = 1'b1;
                WA_FIQ_SET:  stb.fiq_set  = 1'b1;
                WA_FIQ_CLR:  stb.fiq_clr  = 1'b1;
                WA_SOFT_SET: stb.soft_set = 1'b1;
                WA_SOFT_CLR: stb.soft_clr = 1'b1;
                default:     stb = '0;
            endcase
        end
    end

    always_comb begin
        rdata    = '0;
        bad_word = 1'b0;
        case (bus_addr)
            WA_IRQ_STAT: rdata = DATA_W'(level & irq_en);
            WA_FIQ_STAT: rdata = DATA_W'(level & fiq_en);
            WA_IRQ_RAW,
            WA_FIQ_RAW:  rdata = DATA_W'(level);
            WA_IRQ_SET:  rdata = DATA_W'(irq_en);
            WA_FIQ_SET:  rdata = DATA_W'(fiq_en);
            WA_SOFT_SET: rdata = {{(DATA_W-1){1'b0}}, level[0]};
            default:     bad_word = 1'b1;
        endcase
    end

    assign rderr = bus_rd && bad_word;
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rderr,
    output logic              irq_out,
    output logic              fiq_out
);
    wr_strobe_t       stb;
    logic [N_SRC-1:0] level;
    logic [N_SRC-1:0] en_q [N_CH];
    logic [N_CH-1:0]  req;

    irqc_level #(.N_SRC(N_SRC)) u_level (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .soft_set (stb.soft_set),
        .soft_clr (stb.soft_clr),
        .wbit0    (bus_wdata[0]),
        .level    (level)
    );

    irqc_decode #(.N_SRC(N_SRC)) u_decode (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .level    (level),
        .irq_en   (en_q[0]),
        .fiq_en   (en_q[1]),
        .stb      (stb),
        .rdata    (bus_rdata),
        .rderr    (bus_rderr)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic set_s, clr_s, hit_q;
        assign set_s = (ch == 0) ? stb.irq_set : stb.fiq_set;
        assign clr_s = (ch == 0) ? stb.irq_clr : stb.fiq_clr;

        irqc_mask_reg #(.W(N_SRC)) u_mask (
            .clk     (clk),
            .rst     (rst),
            .set_stb (set_s),
            .clr_stb (clr_s),
            .wbits   (bus_wdata[N_SRC-1:0]),
            .mask_q  (en_q[ch])
        );

        always_ff @(posedge clk) begin
            if (rst) hit_q <= 1'b0;
            else     hit_q <= |(level & en_q[ch]);
        end
        assign req[ch] = hit_q;

        a_r7_out_tracks: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (hit_q == (|($past(level) & $past(en_q[ch])))));
    end

    assign irq_out = req[0];
    assign fiq_out = req[1];

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq_out && !fiq_out));
    a_r8_wo_read_err: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == WA_IRQ_CLR || bus_addr == WA_SOFT_CLR ||
                    bus_addr == WA_FIQ_CLR)) |-> (bus_rderr && bus_rdata == '0));
    a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_status_word(bus_addr)) |=>
            ($stable(en_q[0]) && $stable(en_q[1]) && $stable(level[0]) || $past(src_in[0]) != 1'b0 || level[0] == 1'b0));
endmodule

// File: tb/tb_dual_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rderr, irq_out, fiq_out;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dual_irq_ctrl dut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rderr(bus_rderr), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic e);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        d = bus_rdata; e = bus_rderr;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d; logic e;
        rd(a, d, e);
        check(req, d, exp);
        check(req, {31'b0, e}, 32'd0);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rdchk("R1", 6'd2, 32'h0);
        rdchk("R1", 6'd10, 32'h0);
        rdchk("R1", 6'd4, 32'h0);
        check("R1", {30'b0, irq_out, fiq_out}, 32'h0);
    endtask

    task automatic t_masks;
        wr(6'd2, 32'h0000_00F0);
        wr(6'd2, 32'h8000_0001);
        rdchk("R3", 6'd2, 32'h8000_00F1);
        wr(6'd3, 32'h0000_0030);
        rdchk("R3", 6'd2, 32'h8000_00C1);
        rdchk("R4", 6'd10, 32'h0);
        wr(6'd10, 32'h0000_FF00);
        wr(6'd11, 32'h0000_0F00);
        rdchk("R4", 6'd10, 32'h0000_F000);
        rdchk("R3", 6'd2, 32'h8000_00C1);
    endtask

    task automatic t_raw_status;
        set_src(32'h8000_3042);
        rdchk("R2", 6'd1, 32'h8000_3042);
        rdchk("R2", 6'd9, 32'h8000_3042);
        rdchk("R5", 6'd0, 32'h8000_0040);
        rdchk("R5", 6'd8, 32'h0000_3000);
        set_src(32'h0);
        rdchk("R5", 6'd0, 32'h0);
    endtask

    task automatic t_soft;
        wr(6'd4, 32'hFFFF_FFFE);
        rdchk("R6", 6'd4, 32'h0);
        wr(6'd4, 32'h1);
        rdchk("R6", 6'd4, 32'h1);
        rdchk("R2", 6'd1, 32'h1);
        wr(6'd5, 32'h2);
        rdchk("R6", 6'd4, 32'h1);
        set_src(32'h0000_0003);
        rdchk("R6", 6'd4, 32'h1);
        wr(6'd5, 32'h1);
        rdchk("R2", 6'd1, 32'h3);
        set_src(32'h0);
        rdchk("R6", 6'd4, 32'h0);
    endtask

    task automatic t_output_timing;
        // IRQ mask holds bits 0,6,7,31; FIQ mask holds bits 12..15
        @(negedge clk);
        src_in = 32'h0000_0080;
        @(negedge clk);
        check("R7", {31'b0, irq_out}, 32'd0);
        @(negedge clk);
        check("R7", {31'b0, irq_out}, 32'd1);
        check("R7", {31'b0, fiq_out}, 32'd0);
        src_in = 32'h0000_2000;
        @(negedge clk);
        @(negedge clk);
        check("R7", {31'b0, irq_out}, 32'd0);
        check("R7", {31'b0, fiq_out}, 32'd1);
        wr(6'd11, 32'h0000_2000);
        check("R7", {31'b0, fiq_out}, 32'd1);
        @(negedge clk);
        check("R7", {31'b0, fiq_out}, 32'd0);
        src_in = 32'h0;
        wr(6'd4, 32'h1);
        @(negedge clk);
        check("R7", {31'b0, irq_out}, 32'd1);
        wr(6'd5, 32'h1);
        @(negedge clk);
        check("R7", {31'b0, irq_out}, 32'd0);
    endtask

    task automatic t_bad_read;
        logic [31:0] d; logic e;
        foreach (bus_addr_list[i]) begin
            rd(bus_addr_list[i], d, e);
            check("R8", d, 32'h0);
            check("R8", {31'b0, e}, 32'd1);
        end
    endtask
    logic [5:0] bus_addr_list [4] = '{6'd3, 6'd5, 6'd11, 6'd20};

    task automatic t_status_write;
        wr(6'd0, 32'hFFFF_FFFF);
        wr(6'd1, 32'hFFFF_FFFF);
        wr(6'd8, 32'hFFFF_FFFF);
        wr(6'd9, 32'h1);
        rdchk("R9", 6'd2, 32'h8000_00C1);
        rdchk("R9", 6'd10, 32'h0000_D000);
        rdchk("R9", 6'd4, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masks();
        t_raw_status();
        t_soft();
        t_output_timing();
        t_bad_read();
        t_status_write();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule